// File: doc/BRIEF.md
# Fault Protection and Auto-Restart Sequencer

This block is the digital supervisor of an off-line flyback controller. It reads the outputs of a set of analog comparators and decides when the converter runs and when it enters auto-restart after a fault. It also decides how the converter comes back from auto-restart. The comparator flags cover:

- supply overvoltage (above 20.5 V)
- overtemperature
- supply undervoltage (below 10.3 V)
- supply turn-on (above 18 V)
- feedback above 4.5 V
- soft-start above 4.0 V

The block drives four outputs: the bias enable, the high-voltage startup cell enable, the soft-start discharge switch, and a two-bit fault class.

The block has three phases:

- **Charging:** the startup cell is on and the soft-start capacitor is held discharged.
- **Running:** bias is on.
- **Restart wait:** bias and the startup cell are both off, and the block waits for the supply to drain.

The block does not restart on a timer. Restart comes from the gap between the turn-on and turn-off supply thresholds. The supply drains below the low threshold, the startup cell recharges it past the high threshold, and a fresh startup begins from a discharged soft-start capacitor.

Faults fall into two classes:

- **Class I (overvoltage, overtemperature):** the condition must stay present for a fixed spike-blanking time, counted in clock cycles.
- **Class II (overload, open loop):** qualified by the external soft-start window, so it fires as soon as high feedback coincides with soft-start above its threshold.

Top module: `fault_restart_seq`

## Requirements
- R1: After reset the block is in the charging phase: startup_en=1, bias_en=0, ss_discharge=1, fault_class=00.
- R2: In the charging phase, vcc_on high at a clock edge moves the block to running. From the next cycle bias_en=1, startup_en=0, ss_discharge=0 and fault_class is cleared to 00.
- R3: In the charging phase, vcc_uv, vcc_ov, over_temp, fb_high and ss_high have no effect. The outputs stay in the charging values until vcc_on is seen.
- R4: While running, vcc_uv high moves the block straight to charging at the next edge with fault_class=10. This is the path for undervoltage and for a shorted optocoupler.
- R5: While running, over_temp held high for BLANK_CYC consecutive edges (8 µs of clock cycles, 400 at 50 MHz) moves the block to restart wait with fault_class=01. Restart wait means bias_en=0, startup_en=0, ss_discharge=0. After BLANK_CYC-1 edges the block is still running.
- R6: The spike timer restarts from zero whenever the class I condition drops for even one cycle. Pulses of BLANK_CYC-1 edges separated by one low cycle never trip.
- R7: vcc_ov counts as a class I condition only while ss_high=0 and fb_high=1. Otherwise it is ignored however long it lasts.
- R8: While running, fb_high and ss_high both high at an edge move the block to restart wait with fault_class=10 at that edge. fb_high alone does not.
- R9: In restart wait, fault_class holds and vcc_on is ignored. vcc_uv moves the block to charging, and fault_class is held until the next move to running.
- R10: When several conditions coincide while running, vcc_uv wins over both fault classes, and class I wins over class II.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| vcc_ov | input | 1 | Supply above overvoltage threshold |
| over_temp | input | 1 | Junction overtemperature flag |
| vcc_uv | input | 1 | Supply below turn-off threshold |
| vcc_on | input | 1 | Supply above turn-on threshold |
| fb_high | input | 1 | Feedback above overload threshold |
| ss_high | input | 1 | Soft-start above blanking threshold |
| bias_en | output | 1 | Enables internal bias (converter running) |
| startup_en | output | 1 | Enables the high-voltage startup cell |
| ss_discharge | output | 1 | Holds the soft-start capacitor discharged |
| fault_class | output | 2 | 00 none, 01 class I, 10 class II |

## Verification
The bench targets the exact trip point of the spike timer: an over-temperature lasting one cycle short of the window must leave the converter running, and one cycle more must stop it. A design with an off-by-one counter would trip early or late. It also checks that the timer restarts after a one-cycle dropout; a design that only pauses its counter would trip on the second pulse. Overvoltage is driven under each combination of the soft-start and feedback flags, because a design that left it unqualified would shut down during normal high-feedback transients. The bench also covers the hysteresis path, checking that turn-on is ignored during restart wait and that undervoltage is ignored while charging. A design that got either wrong would skip the supply drain or never start.

// File: rtl/fault_restart_seq.sv
module fault_restart_seq #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int BLANK_NS = 8000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_ov,
  input  logic       over_temp,
  input  logic       vcc_uv,
  input  logic       vcc_on,
  input  logic       fb_high,
  input  logic       ss_high,
  output logic       bias_en,
  output logic       startup_en,
  output logic       ss_discharge,
  output logic [1:0] fault_class
);

  localparam int RAW_CYC   = (CLK_HZ / 1000) * BLANK_NS / 1_000_000;
  localparam int BLANK_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;
  localparam int CW        = $clog2(BLANK_CYC + 1);
  localparam logic [1:0] FC_NONE = 2'b00;
  localparam logic [1:0] FC_ONE  = 2'b01;
  localparam logic [1:0] FC_TWO  = 2'b10;

  typedef enum logic [1:0] {CHARGE, RUN, HOLD} phase_t;

  phase_t        phase;
  logic [CW-1:0] blank_cnt;

  wire c1_cond = over_temp | (vcc_ov & fb_high & ~ss_high);
  wire c1_trip = c1_cond && (blank_cnt == CW'(BLANK_CYC - 1));
  wire c2_trip = fb_high & ss_high;

  assign bias_en      = (phase == RUN);
  assign startup_en   = (phase == CHARGE);
  assign ss_discharge = (phase == CHARGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= CHARGE;
      blank_cnt   <= '0;
      fault_class <= FC_NONE;
    end else begin
      blank_cnt <= (phase == RUN && c1_cond && !c1_trip) ? blank_cnt + 1'b1 : '0;
      case (phase)
        CHARGE:
          if (vcc_on) begin
            phase       <= RUN;
            fault_class <= FC_NONE;
          end
        RUN:
          if (vcc_uv) begin
            phase       <= CHARGE;
            fault_class <= FC_TWO;
          end else if (c1_trip) begin
            phase       <= HOLD;
            fault_class <= FC_ONE;
          end else if (c2_trip) begin
            phase       <= HOLD;
            fault_class <= FC_TWO;
          end
        HOLD:
          if (vcc_uv) phase <= CHARGE;
        default: phase <= CHARGE;
      endcase
    end
  end

  a_r2_turn_on: assert property (@(posedge clk) disable iff (!rst_n)
    (startup_en && vcc_on) |=> (bias_en && !startup_en && fault_class == 2'b00));

  a_r3_charge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (startup_en && !vcc_on) |=> (startup_en && ss_discharge && $stable(fault_class)));

  a_r4_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_en && vcc_uv) |=> (startup_en && fault_class == 2'b10));

  a_r5_no_class1_without_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_en && !over_temp && !vcc_ov) |=> (fault_class != 2'b01));

  a_r8_class2_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_en && !vcc_uv && fb_high && ss_high) |=> (!bias_en && !startup_en && fault_class != 2'b00));

  a_r9_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (!bias_en && !startup_en && !vcc_uv) |=> (!bias_en && !startup_en && $stable(fault_class)));

endmodule

// File: tb/sim_fault_restart_seq.sv
module sim_fault_restart_seq;
  localparam int BLANK = 400; // 8 us at 50 MHz

  logic clk = 0, rst_n = 0;
  logic vcc_ov = 0, over_temp = 0, vcc_uv = 0, vcc_on = 0, fb_high = 0, ss_high = 0;
  logic bias_en, startup_en, ss_discharge;
  logic [1:0] fault_class;
  int n_chk = 0, n_bad = 0;

  fault_restart_seq u0 (.clk, .rst_n, .vcc_ov, .over_temp, .vcc_uv, .vcc_on,
    .fb_high, .ss_high, .bias_en, .startup_en, .ss_discharge, .fault_class);

  always #10 clk = ~clk;

  localparam logic [4:0] S_CHG = 5'b01100;
  localparam logic [4:0] S_RUN = 5'b10000;

  task automatic chk(string req, logic [4:0] exp);
    logic [4:0] act;
    act = {bias_en, startup_en, ss_discharge, fault_class};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clr();
    {vcc_ov, over_temp, vcc_uv, vcc_on, fb_high, ss_high} = '0;
  endtask

  task automatic restart_run();
    clr();
    rst_n = 0; edges(2); rst_n = 1; edges(1);
    vcc_on = 1; edges(1); vcc_on = 0;
  endtask

  task automatic t_reset();
    clr(); rst_n = 0; edges(2);
    chk("R1 reset", S_CHG);
    rst_n = 1; edges(3);
    chk("R1 after release", S_CHG);
  endtask

  task automatic t_off_ignore();
    vcc_uv = 1; over_temp = 1; vcc_ov = 1; fb_high = 1; ss_high = 1;
    edges(BLANK + 3);
    chk("R3 charging ignores faults", S_CHG);
    clr(); vcc_on = 1; edges(1); vcc_on = 0;
    chk("R2 turn on", S_RUN);
  endtask

  task automatic t_uv();
    restart_run();
    vcc_uv = 1; edges(1); vcc_uv = 0;
    chk("R4 undervoltage off", {3'b011, 2'b10});
    vcc_on = 1; edges(1); vcc_on = 0;
    chk("R2 class cleared on restart", S_RUN);
  endtask

  task automatic t_class1_edge();
    restart_run();
    over_temp = 1; edges(BLANK - 1);
    chk("R5 one short of window", S_RUN);
    edges(1); over_temp = 0;
    chk("R5 trip at window", {3'b000, 2'b01});
  endtask

  task automatic t_timer_restart();
    restart_run();
    over_temp = 1; edges(BLANK - 1);
    over_temp = 0; edges(1);
    over_temp = 1; edges(BLANK - 1);
    over_temp = 0; edges(2);
    chk("R6 timer restarts on dropout", S_RUN);
  endtask

  task automatic t_ov_qual();
    restart_run();
    vcc_ov = 1; edges(BLANK + 5);
    chk("R7 ov without high feedback", S_RUN);
    ss_high = 1; edges(BLANK + 5);
    chk("R7 ov with soft-start high", S_RUN);
    ss_high = 0; fb_high = 1; edges(BLANK - 1);
    chk("R7 qualified ov short of window", S_RUN);
    edges(1); clr();
    chk("R7 qualified ov trip", {3'b000, 2'b01});
  endtask

  task automatic t_class2();
    restart_run();
    fb_high = 1; edges(20);
    chk("R8 feedback alone", S_RUN);
    ss_high = 1; edges(1); clr();
    chk("R8 overload trip", {3'b000, 2'b10});
  endtask

  task automatic t_hold();
    edges(10);
    chk("R9 waits for drain", {3'b000, 2'b10});
    vcc_on = 1; edges(3);
    chk("R9 turn-on ignored in wait", {3'b000, 2'b10});
    vcc_on = 0; vcc_uv = 1; edges(1); vcc_uv = 0;
    chk("R9 drain to charging, class held", {3'b011, 2'b10});
    vcc_on = 1; edges(1); vcc_on = 0;
    chk("R9 new startup clears class", S_RUN);
  endtask

  task automatic t_priority();
    restart_run();
    vcc_uv = 1; fb_high = 1; ss_high = 1; over_temp = 1; edges(1); clr();
    chk("R10 undervoltage wins", {3'b011, 2'b10});
    restart_run();
    over_temp = 1; edges(BLANK - 1);
    fb_high = 1; ss_high = 1; edges(1); clr();
    chk("R10 class I over class II", {3'b000, 2'b01});
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_off_ignore();
    t_uv();
    t_class1_edge();
    t_timer_restart();
    t_ov_qual();
    t_class2();
    t_hold();
    t_priority();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule